// File: doc/BRIEF.md
# Lookup-Table Sector Cache

This block is a small read-only cache placed beside a cipher datapath to serve substitution-table reads. It holds a single 1 KB table, and that table is identified by one tag: the table's virtual base address. The storage is split into 32-byte sectors, and each sector has its own valid bit. A lookup carries a table base and a byte index into the table. A hit returns the addressed 32-bit entry two cycles after the request is accepted. Because the tag is virtual, a hit needs no address translation.

When a lookup names a base other than the stored one, the cache drops every sector and adopts the new base. In all miss cases it fetches only the touched sector from a backing data-cache port, as eight 32-bit beats. The stalled lookup then completes as an ordinary hit. Two commands invalidate contents. A sync clears every sector valid bit and keeps the tag. A context switch invalidates the tag itself. Either command cancels a refill that is in progress, and any beats still owed for that refill are swallowed. The cache never holds modified data, so nothing is ever written back.

Top module: `sbox_sector_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `fill_req_valid` are 0, and the first lookup misses.
- R2: A lookup that hits asserts `rsp_valid` exactly two cycles after its acceptance cycle. Cycle 0 is the cycle in which `req_valid` and `req_ready` are both high. The response data is the 32-bit word at byte address base + index with index bits [1:0] cleared.
- R3: Lookups that hit can be accepted on consecutive cycles. `req_ready` stays high, and the responses come out in order, one per cycle.
- R4: A miss drops `req_ready` and raises `fill_req_valid` with `fill_req_addr` = base + index[9:5]*32. The address stays stable until `fill_req_ready`, and each miss makes exactly one fill request.
- R5: A refill takes eight beats strobed by `fill_beat_valid`. Beat k carries the word at byte offset 4k of the sector. After the eighth beat, the stalled lookup returns the correct word.
- R6: Only the touched sector is fetched. Another sector of the same table still misses, while the filled sector hits with no fill request.
- R7: A lookup with a different base flushes all sectors. Sectors of the previous table that had been filled miss again once that table is used again.
- R8: A sync pulse makes the next lookup of a previously filled sector miss and re-fetch it.
- R9: A context-switch pulse makes the next lookup miss, even for a sector that was valid.
- R10: A sync or context switch during a refill cancels it. Remaining beats are discarded and never reach a response, no fill request is raised while they drain, and the lookup is then re-fetched and answered with correct data. In the cycle after either command, `fill_req_valid` is 0.
- R11: Index bits [1:0] do not affect the result. Index 0x01F returns the same word as index 0x01C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_base | input | ADDR_W | Virtual base address of the table |
| req_index | input | IDX_W | Byte index into the table |
| rsp_valid | output | 1 | Lookup result present |
| rsp_data | output | DATA_W | Table entry |
| sync_i | input | 1 | Clear all sector valid bits |
| ctx_switch_i | input | 1 | Invalidate the tag |
| fill_req_valid | output | 1 | Sector fetch request to backing cache |
| fill_req_ready | input | 1 | Backing cache takes the request |
| fill_req_addr | output | ADDR_W | Byte address of the sector |
| fill_beat_valid | input | 1 | Fill beat present |
| fill_beat_data | input | DATA_W | Fill beat word |

## Verification
The main lookup function is driven with a sequence that alternates between two table bases and visits several sectors. That sequence separates hits inside a filled sector, misses to untouched sectors of the same table, and misses caused by a base change that flushed earlier sectors. The backing port returns a distinct word for every address, so a wrong sector, a wrong word or a wrong beat order shows up as wrong data. An index with nonzero low bits tells word alignment apart from byte selection. Back-to-back hits expose any bubble in the pipeline. Separate sync, context-switch and mid-refill cancel cases distinguish invalidation from stale data, and show whether drained beats leak into the array.

// File: rtl/sbox_sector_cache.sv
module sbox_sector_cache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int TABLE_BYTES = 1024,
  parameter int IDX_W       = $clog2(TABLE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IDX_W-1:0]  req_index,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              sync_i,
  input  logic              ctx_switch_i,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_beat_valid,
  input  logic [DATA_W-1:0] fill_beat_data
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WPL        = LINE_BYTES / WORD_BYTES;
  localparam int NSEC       = TABLE_BYTES / LINE_BYTES;
  localparam int NWORDS     = TABLE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BOFF_W     = $clog2(WORD_BYTES);
  localparam int SEC_W      = IDX_W - OFF_W;
  localparam int WSEL_W     = OFF_W - BOFF_W;
  localparam int CW         = WSEL_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_BEAT, ST_DRAIN} st_t;

  st_t               st;
  logic              tag_ok;
  logic [ADDR_W-1:0] tag_q;
  logic [NSEC-1:0]   sec_vld;
  logic [DATA_W-1:0] mem [NWORDS];

  logic              s1_vld;
  logic [ADDR_W-1:0] s1_base;
  logic [IDX_W-1:0]  s1_idx;
  logic [WSEL_W-1:0] cnt;
  logic [CW-1:0]     drain_q;

  wire [SEC_W-1:0]  s1_sec   = s1_idx[IDX_W-1:OFF_W];
  wire [WSEL_W-1:0] s1_word  = s1_idx[OFF_W-1:BOFF_W];
  wire              cmd      = sync_i | ctx_switch_i;
  wire              idle     = (st == ST_IDLE);
  wire              tag_hit  = tag_ok && (tag_q == s1_base);
  wire              s1_hit   = tag_hit && sec_vld[s1_sec];
  wire              advance  = idle && s1_vld && s1_hit && !cmd;
  wire              start_ms = idle && s1_vld && !s1_hit && !cmd;
  wire              last     = (cnt == WSEL_W'(WPL - 1));
  wire              beat_ok  = (st == ST_BEAT) && fill_beat_valid && !cmd;
  wire [CW-1:0]     drain_left = CW'(WPL) - {1'b0, cnt} - {{WSEL_W{1'b0}}, fill_beat_valid};

  logic unused_lsb;
  assign unused_lsb = ^s1_idx[BOFF_W-1:0];

  assign req_ready      = idle && (!s1_vld || advance);
  assign fill_req_valid = (st == ST_REQ);
  assign fill_req_addr  = s1_base + ADDR_W'({s1_sec, {OFF_W{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_base <= '0;
      s1_idx  <= '0;
    end else if (req_valid && req_ready) begin
      s1_vld  <= 1'b1;
      s1_base <= req_base;
      s1_idx  <= req_index;
    end else if (advance) begin
      s1_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      drain_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_ms) st <= ST_REQ;
        ST_REQ: begin
          if (cmd) begin
            if (fill_req_ready) begin
              st      <= ST_DRAIN;
              drain_q <= CW'(WPL);
            end else begin
              st <= ST_IDLE;
            end
          end else if (fill_req_ready) begin
            st  <= ST_BEAT;
            cnt <= '0;
          end
        end
        ST_BEAT: begin
          if (cmd) begin
            drain_q <= drain_left;
            st      <= (drain_left == '0) ? ST_IDLE : ST_DRAIN;
          end else if (fill_beat_valid) begin
            cnt <= cnt + 1'b1;
            if (last) st <= ST_IDLE;
          end
        end
        default: begin
          if (fill_beat_valid) begin
            drain_q <= drain_q - 1'b1;
            if (drain_q == CW'(1)) st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_ok  <= 1'b0;
      tag_q   <= '0;
      sec_vld <= '0;
    end else begin
      if (start_ms && !tag_hit) begin
        sec_vld <= '0;
        tag_q   <= s1_base;
        tag_ok  <= 1'b1;
      end
      if (beat_ok && last) sec_vld[s1_sec] <= 1'b1;
      if (sync_i) sec_vld <= '0;
      if (ctx_switch_i) tag_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_ok) mem[{s1_sec, cnt}] <= fill_beat_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= advance;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_data <= '0;
    else if (advance) rsp_data <= mem[{s1_sec, s1_word}];
  end
endmodule

// File: rtl/sbox_sector_cache_chk.sv
module sbox_sector_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sync_i,
  input logic              ctx_switch_i,
  input logic              fill_req_valid,
  input logic              fill_req_ready,
  input logic [ADDR_W-1:0] fill_req_addr
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && !fill_req_valid));

  assert_stall_during_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !req_ready);

  assert_hold_fill_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready && !sync_i && !ctx_switch_i)
      |=> (fill_req_valid && $stable(fill_req_addr)));

  assert_no_rsp_while_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !fill_req_valid);

  assert_cmd_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i || ctx_switch_i) |=> !fill_req_valid);
endmodule

bind sbox_sector_cache sbox_sector_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sync_i(sync_i), .ctx_switch_i(ctx_switch_i), .fill_req_valid(fill_req_valid),
  .fill_req_ready(fill_req_ready), .fill_req_addr(fill_req_addr)
);

// File: tb/test_sbox_sector_cache.sv
`timescale 1ns/1ps
module test_sbox_sector_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [9:0]  req_index = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        sync_i = 1'b0;
  logic        ctx_switch_i = 1'b0;
  logic        fill_req_valid;
  logic        fill_req_ready = 1'b1;
  logic [31:0] fill_req_addr;
  logic        fill_beat_valid = 1'b0;
  logic [31:0] fill_beat_data = '0;

  int checks = 0;
  int failures = 0;
  int fills = 0;
  logic [31:0] last_fill = '0;
  bit auto_fill = 1'b1;

  localparam logic [31:0] BASE_A = 32'h0001_0000;
  localparam logic [31:0] BASE_B = 32'h0002_0400;
  // entry: {base select (0=A,1=B), index[9:0], expect miss}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 10'h000, 1'b1}, {1'b0, 10'h004, 1'b0}, {1'b0, 10'h01F, 1'b0},
    {1'b0, 10'h020, 1'b1}, {1'b0, 10'h000, 1'b0}, {1'b0, 10'h3FC, 1'b1},
    {1'b0, 10'h3FD, 1'b0}, {1'b1, 10'h000, 1'b1}, {1'b0, 10'h020, 1'b1},
    {1'b0, 10'h3FC, 1'b1}, {1'b0, 10'h024, 1'b0}, {1'b1, 10'h3FC, 1'b1}};

  always #4 clk = ~clk;

  sbox_sector_cache i_sbox_sector_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_index(req_index), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sync_i(sync_i), .ctx_switch_i(ctx_switch_i),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_beat_valid(fill_beat_valid),
    .fill_beat_data(fill_beat_data));

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // backing-cache responder: eight in-order beats per accepted request
  initial begin
    forever begin
      @(negedge clk);
      if (auto_fill && fill_req_valid) begin
        logic [31:0] a;
        a = fill_req_addr;
        fills++;
        last_fill = a;
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          fill_beat_valid = 1'b1;
          fill_beat_data  = mem_word(a + 32'(4 * k));
        end
        @(negedge clk);
        fill_beat_valid = 1'b0;
      end
    end
  end

  task automatic lookup(input logic [31:0] b, input logic [9:0] ix,
                        output logic [31:0] d, output int lat, output bit got);
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_index = ix;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
    got = rsp_valid;
    d = rsp_data;
  endtask

  task automatic pulse(input bit is_sync);
    @(negedge clk);
    if (is_sync) sync_i = 1'b1; else ctx_switch_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0; ctx_switch_i = 1'b0;
  endtask

  task automatic expect_lookup(input logic [31:0] b, input logic [9:0] ix,
                               input bit miss, input string req);
    logic [31:0] d; int lat; bit got; int f0;
    logic [31:0] ea;
    f0 = fills;
    lookup(b, ix, d, lat, got);
    ea = b + {22'd0, ix[9:2], 2'b00};
    chk(got && d == mem_word(ea), req, "data", d, mem_word(ea));
    chk(fills - f0 == int'(miss), req, "fill count", 32'(fills - f0), 32'(miss));
    if (miss)
      chk(last_fill == b + {22'd0, ix[9:5], 5'd0}, req, "fill addr",
          last_fill, b + {22'd0, ix[9:5], 5'd0});
    else
      chk(lat == 2, req, "hit latency", 32'(lat), 32'd2);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(fill_req_valid == 1'b0, "R1", "fill_req_valid", 32'(fill_req_valid), 32'd0);

    // vector walk: R1 first miss, R2/R11 hits, R4/R5 misses, R6 sectors, R7 flush
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (v == 0)                 tag = "R1";
      else if (VEC[v][2:1] != 0)  tag = "R11";
      else if (v >= 7 && v <= 9)  tag = "R7";
      else if (v == 3 || v == 5)  tag = "R6";
      else if (VEC[v][0])         tag = "R5";
      else                        tag = "R2";
      expect_lookup(VEC[v][11] ? BASE_B : BASE_A, VEC[v][10:1], VEC[v][0], tag);
    end

    // R3 back-to-back hits in sector 31 of table B
    begin
      int f0;
      f0 = fills;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        #1;
        if (i >= 2) begin
          chk(rsp_valid == 1'b1, "R3", "rsp_valid", 32'(rsp_valid), 32'd1);
          chk(rsp_data == mem_word(BASE_B + 32'h3E0 + 32'(4 * (i - 2))), "R3",
              "data", rsp_data, mem_word(BASE_B + 32'h3E0 + 32'(4 * (i - 2))));
        end
        if (i < 4) begin
          chk(req_ready == 1'b1, "R3", "req_ready", 32'(req_ready), 32'd1);
          req_valid = 1'b1; req_base = BASE_B; req_index = 10'(10'h3E0 + 4 * i);
        end else begin
          req_valid = 1'b0;
        end
      end
      chk(fills == f0, "R3", "no fill", 32'(fills), 32'(f0));
    end

    // R8 sync then refetch; R9 context switch then miss
    pulse(1'b1);
    expect_lookup(BASE_B, 10'h3E4, 1'b1, "R8");
    expect_lookup(BASE_B, 10'h3E8, 1'b0, "R8");
    pulse(1'b0);
    expect_lookup(BASE_B, 10'h3EC, 1'b1, "R9");

    // R10 sync in the middle of a refill
    auto_fill = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_base = BASE_A; req_index = 10'h048;
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 20 && !fill_req_valid; w++) @(negedge clk);
    chk(fill_req_valid == 1'b1, "R10", "fill request", 32'(fill_req_valid), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fill_beat_valid = 1'b1;
      fill_beat_data  = mem_word(BASE_A + 32'h40 + 32'(4 * k));
    end
    @(negedge clk);
    fill_beat_valid = 1'b0;
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    #1;
    chk(fill_req_valid == 1'b0, "R10", "no request after cancel", 32'(fill_req_valid), 32'd0);
    for (int k = 0; k < 5; k++) begin
      fill_beat_valid = 1'b1;
      fill_beat_data  = 32'hBAD0_0000 + 32'(k);
      @(negedge clk);
      #1;
      chk(fill_req_valid == 1'b0, "R10", "drain quiet", 32'(fill_req_valid), 32'd0);
    end
    fill_beat_valid = 1'b0;
    begin
      int f0; int w;
      f0 = fills;
      auto_fill = 1'b1;
      w = 0;
      while (!rsp_valid && w < 60) begin @(negedge clk); w++; end
      chk(rsp_valid == 1'b1, "R10", "response", 32'(rsp_valid), 32'd1);
      chk(rsp_data == mem_word(BASE_A + 32'h48), "R10", "data after cancel",
          rsp_data, mem_word(BASE_A + 32'h48));
      chk(fills - f0 == 1, "R10", "refetch", 32'(fills - f0), 32'd1);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule